// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous two-port static memory, 2048 words of 8 bits by default. It lets two processors share data and signal each other. Each side has its own enable, output enable, write strobe, address, write data, and a write-inhibit input driven by an external arbiter. Either side can read or write any word. Reads return data on the clock after the address is presented. A write updates the array on the clock edge.

Two words at the top of the address space also act as mailboxes. When the left side writes the highest word, an active-low interrupt is raised toward the right side. When the right side writes the word just below it, an interrupt is raised toward the left side. Each receiving side clears its own interrupt by accessing its mailbox word with enable and output enable both active. Both mailbox words stay ordinary storage. Reset returns both interrupts to inactive and leaves the array contents alone.

Top module: `mbox_dpram`

## Requirements
- R1: Either side can write any of the 2048 words, and either side can read any of them back. Read data appears on the read-data output one clock after the address, enable and output enable are presented.
- R2: A word is written only when that side's enable and write strobe are both high and its write-inhibit input is low. A write attempted with write-inhibit high leaves the memory unchanged.
- R3: The read-data output is driven only on the cycle after enable and output enable are high with the write strobe low, and the drive flag marks that cycle. On every other cycle the drive flag is low and the read-data output is all zeros.
- R4: A non-inhibited left-side write to address 0x7FF drives the right interrupt output low on the next clock. The written byte is stored like any other word.
- R5: A non-inhibited right-side write to address 0x7FE drives the left interrupt output low on the next clock. The written byte is stored like any other word.
- R6: The right interrupt returns high on the clock after the right side presents address 0x7FF with enable and output enable high, whatever its write strobe level. The left interrupt is cleared the same way, by the left side at 0x7FE. Enable without output enable does not clear an interrupt.
- R7: A mailbox write attempted with write-inhibit high changes neither the peer interrupt nor the mailbox byte.
- R8: When an interrupt is set and cleared in the same cycle, the set wins and the interrupt output stays low.
- R9: While reset is active, both interrupt outputs are high (inactive), the drive flags are low and the read data is zero. Memory contents written before reset remain readable after it.
- R10: When both sides write the same address in the same cycle with write-inhibit low, the left side's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset of interrupts and read registers |
| l_en | input | 1 | Left enable |
| l_oe | input | 1 | Left output enable |
| l_we | input | 1 | Left write strobe |
| l_inhibit | input | 1 | Left write inhibit from the arbiter |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, zero when not driven |
| l_rd_vld | output | 1 | Left read data is being driven |
| l_irq_n | output | 1 | Interrupt toward the left side, active low |
| r_en | input | 1 | Right enable |
| r_oe | input | 1 | Right output enable |
| r_we | input | 1 | Right write strobe |
| r_inhibit | input | 1 | Right write inhibit from the arbiter |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, zero when not driven |
| r_rd_vld | output | 1 | Right read data is being driven |
| r_irq_n | output | 1 | Interrupt toward the right side, active low |

## Verification
On every clock, assertions check the interrupt behaviour. A non-inhibited mailbox write must pull the peer interrupt low on the next edge. A clear access with no competing set must release it. The interrupt must hold its value when neither event occurs, which covers inhibited mailbox writes. The read output must be silent after any cycle without a read request. Only the bench's scenarios can show that data really moves through the array. These scenarios cover cross-side reads, writes lost to inhibit, left-wins collisions, the old-data result when a read meets a write, and words that survive a reset. The bench compares every output against its reference model on each cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   // Control strobes presented by one side in one cycle.
   typedef struct packed {
      logic en;
      logic oe;
      logic we;
      logic inhibit;
   } side_ctl_t;

   // Decoded intent of one side in one cycle.
   typedef struct packed {
      logic wr_go;     // write reaches the array
      logic rd_go;     // read output will be driven
      logic clr_own;   // access that acknowledges this side's mailbox
      logic set_peer;  // write that rings the other side
   } side_dec_t;

endpackage

// File: rtl/mbox_side_dec.sv
module mbox_side_dec
   import mbox_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int OWN_BOX  = 2046,
   parameter int PEER_BOX = 2047
) (
   input  side_ctl_t          ctl,
   input  logic [ADDR_W-1:0]  addr,
   output side_dec_t          dec
);

   localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
   localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

   if (OWN_BOX == PEER_BOX) begin : g_bad_boxes
      $error("mbox_side_dec: mailbox addresses must differ");
   end

   logic wr_req;

   always_comb begin
      wr_req       = ctl.en & ctl.we;
      dec.wr_go    = wr_req & ~ctl.inhibit;
      dec.rd_go    = ctl.en & ctl.oe & ~ctl.we;
      dec.clr_own  = ctl.en & ctl.oe & (addr == OWN_A);
      dec.set_peer = dec.wr_go & (addr == PEER_A);
   end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);

   if (ENABLE) begin : g_live
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q <= 1'b0;
         else if (set)
            pend_q <= 1'b1;          // set outranks clear
         else if (clr)
            pend_q <= 1'b0;
      end
      assign irq_n = ~pend_q;
   end else begin : g_off
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ set ^ clr;
      assign irq_n     = 1'b1;
   end

endmodule

// File: rtl/mbox_array.sv
module mbox_array #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_wr,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic              a_rd,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_vld,
   input  logic              b_wr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   input  logic              b_rd,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_vld
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
      $error("mbox_array: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("mbox_array: DATA_W must be positive");
   end

   logic [DATA_W-1:0] cells [DEPTH];

   // Array update; the second write in program order wins a collision.
   if (LEFT_WINS) begin : g_left_first
      always_ff @(posedge clk) begin
         if (b_wr) cells[b_addr] <= b_wdata;
         if (a_wr) cells[a_addr] <= a_wdata;
      end
   end else begin : g_right_first
      always_ff @(posedge clk) begin
         if (a_wr) cells[a_addr] <= a_wdata;
         if (b_wr) cells[b_addr] <= b_wdata;
      end
   end

   // Registered reads see the contents before this edge's writes.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rdata <= '0;
         a_vld   <= 1'b0;
         b_rdata <= '0;
         b_vld   <= 1'b0;
      end else begin
         a_vld   <= a_rd;
         b_vld   <= b_rd;
         a_rdata <= a_rd ? cells[a_addr] : '0;
         b_rdata <= b_rd ? cells[b_addr] : '0;
      end
   end

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
   import mbox_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 8,
   parameter bit MBOX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              l_oe,
   input  logic              l_we,
   input  logic              l_inhibit,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rd_vld,
   output logic              l_irq_n,
   input  logic              r_en,
   input  logic              r_oe,
   input  logic              r_we,
   input  logic              r_inhibit,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rd_vld,
   output logic              r_irq_n
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int R_BOX  = DEPTH - 1;   // written by left, rings right
   localparam int L_BOX  = DEPTH - 2;   // written by right, rings left
   localparam logic [ADDR_W-1:0] R_BOX_A = ADDR_W'(R_BOX);
   localparam logic [ADDR_W-1:0] L_BOX_A = ADDR_W'(L_BOX);

   side_ctl_t l_ctl, r_ctl;
   side_dec_t l_dec, r_dec;

   assign l_ctl = '{en: l_en, oe: l_oe, we: l_we, inhibit: l_inhibit};
   assign r_ctl = '{en: r_en, oe: r_oe, we: r_we, inhibit: r_inhibit};

   mbox_side_dec #(.ADDR_W(ADDR_W), .OWN_BOX(L_BOX), .PEER_BOX(R_BOX)) u_l_dec (
      .ctl(l_ctl), .addr(l_addr), .dec(l_dec)
   );
   mbox_side_dec #(.ADDR_W(ADDR_W), .OWN_BOX(R_BOX), .PEER_BOX(L_BOX)) u_r_dec (
      .ctl(r_ctl), .addr(r_addr), .dec(r_dec)
   );

   mbox_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEFT_WINS(1'b1)) u_array (
      .clk(clk), .rst_n(rst_n),
      .a_wr(l_dec.wr_go), .a_addr(l_addr), .a_wdata(l_wdata),
      .a_rd(l_dec.rd_go), .a_rdata(l_rdata), .a_vld(l_rd_vld),
      .b_wr(r_dec.wr_go), .b_addr(r_addr), .b_wdata(r_wdata),
      .b_rd(r_dec.rd_go), .b_rdata(r_rdata), .b_vld(r_rd_vld)
   );

   mbox_flag #(.ENABLE(MBOX_EN)) u_l_flag (
      .clk(clk), .rst_n(rst_n), .set(r_dec.set_peer), .clr(l_dec.clr_own), .irq_n(l_irq_n)
   );
   mbox_flag #(.ENABLE(MBOX_EN)) u_r_flag (
      .clk(clk), .rst_n(rst_n), .set(l_dec.set_peer), .clr(r_dec.clr_own), .irq_n(r_irq_n)
   );

   // ---------------- checks on port behaviour ----------------
   logic l_ring, r_ring, l_ack, r_ack;
   assign r_ring = l_en & l_we & ~l_inhibit & (l_addr == R_BOX_A);
   assign l_ring = r_en & r_we & ~r_inhibit & (r_addr == L_BOX_A);
   assign r_ack  = r_en & r_oe & (r_addr == R_BOX_A);
   assign l_ack  = l_en & l_oe & (l_addr == L_BOX_A);

   if (MBOX_EN) begin : g_irq_checks
      assert_rset_R4: assert property (@(posedge clk) disable iff (!rst_n)
         r_ring |=> !r_irq_n);
      assert_lset_R5: assert property (@(posedge clk) disable iff (!rst_n)
         l_ring |=> !l_irq_n);
      assert_rclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (r_ack && !r_ring) |=> r_irq_n);
      assert_lclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (l_ack && !l_ring) |=> l_irq_n);
      assert_rhold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!r_ring && !r_ack) |=> $stable(r_irq_n));
      assert_lhold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!l_ring && !l_ack) |=> $stable(l_irq_n));
   end

   assert_lquiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_en && l_oe && !l_we) |=> (!l_rd_vld && l_rdata == '0));
   assert_rquiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_en && r_oe && !r_we) |=> (!r_rd_vld && r_rdata == '0));
   assert_rst_idle_R9: assert property (@(posedge clk)
      !rst_n |-> (l_irq_n && r_irq_n && !l_rd_vld && !r_rd_vld));

endmodule

// File: tb/mbox_dpram_tb_top.sv
module mbox_dpram_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       l_en = 0, l_oe = 0, l_we = 0, l_inh = 0;
   logic       r_en = 0, r_oe = 0, r_we = 0, r_inh = 0;
   logic [10:0] l_addr = '0, r_addr = '0;
   logic [7:0]  l_wd = '0, r_wd = '0;
   logic [7:0]  l_rd, r_rd;
   logic        l_v, r_v, l_irq_n, r_irq_n;

   mbox_dpram dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_en(l_en), .l_oe(l_oe), .l_we(l_we), .l_inhibit(l_inh),
      .l_addr(l_addr), .l_wdata(l_wd), .l_rdata(l_rd), .l_rd_vld(l_v), .l_irq_n(l_irq_n),
      .r_en(r_en), .r_oe(r_oe), .r_we(r_we), .r_inhibit(r_inh),
      .r_addr(r_addr), .r_wdata(r_wd), .r_rdata(r_rd), .r_rd_vld(r_v), .r_irq_n(r_irq_n)
   );

   // ---------------- behavioural reference ----------------
   logic [7:0] ref_mem [int];
   logic [7:0] e_lrd = 0, e_rrd = 0;
   logic       e_lv = 0, e_rv = 0, e_lirq = 1, e_rirq = 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_lrd = 0; e_rrd = 0; e_lv = 0; e_rv = 0; e_lirq = 1; e_rirq = 1;
      end else begin
         e_lv  = l_en && l_oe && !l_we;
         e_rv  = r_en && r_oe && !r_we;
         e_lrd = e_lv ? ref_mem[int'(l_addr)] : 8'h00;
         e_rrd = e_rv ? ref_mem[int'(r_addr)] : 8'h00;
         if (r_en && r_we && !r_inh && r_addr == 11'h7FE) e_lirq = 0;
         else if (l_en && l_oe && l_addr == 11'h7FE)      e_lirq = 1;
         if (l_en && l_we && !l_inh && l_addr == 11'h7FF) e_rirq = 0;
         else if (r_en && r_oe && r_addr == 11'h7FF)      e_rirq = 1;
         if (r_en && r_we && !r_inh) ref_mem[int'(r_addr)] = r_wd;
         if (l_en && l_we && !l_inh) ref_mem[int'(l_addr)] = l_wd;
      end
   end

   // ---------------- checking ----------------
   int checks = 0, failures = 0;
   string tag = "R9";

   task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      chk("l_rdata", l_rd, e_lrd);
      chk("r_rdata", r_rd, e_rrd);
      chk("l_rd_vld", {7'd0, l_v}, {7'd0, e_lv});
      chk("r_rd_vld", {7'd0, r_v}, {7'd0, e_rv});
      chk("l_irq_n", {7'd0, l_irq_n}, {7'd0, e_lirq});
      chk("r_irq_n", {7'd0, r_irq_n}, {7'd0, e_rirq});
   endtask

   task automatic idle();
      l_en = 0; l_oe = 0; l_we = 0; l_inh = 0;
      r_en = 0; r_oe = 0; r_we = 0; r_inh = 0;
   endtask

   task automatic lop(bit en, bit oe, bit we, bit inh, logic [10:0] a, logic [7:0] d);
      l_en = en; l_oe = oe; l_we = we; l_inh = inh; l_addr = a; l_wd = d;
   endtask

   task automatic rop(bit en, bit oe, bit we, bit inh, logic [10:0] a, logic [7:0] d);
      r_en = en; r_oe = oe; r_we = we; r_inh = inh; r_addr = a; r_wd = d;
   endtask

   task automatic run();
      // R9: reset state
      @(negedge clk);
      tag = "R9";
      cyc(); cyc();
      chk("reset l_irq_n", {7'd0, l_irq_n}, 8'd1);
      chk("reset r_irq_n", {7'd0, r_irq_n}, 8'd1);
      rst_n = 1;
      cyc();

      // R1: cross-side write then read, one-cycle latency
      tag = "R1";
      lop(1, 0, 1, 0, 11'd5, 8'hA5); rop(1, 0, 1, 0, 11'd100, 8'h3C); cyc();
      lop(1, 1, 0, 0, 11'd100, 0);  rop(1, 1, 0, 0, 11'd5, 0);       cyc();
      chk("R1 left reads right word", l_rd, 8'h3C);
      chk("R1 right reads left word", r_rd, 8'hA5);
      lop(1, 0, 1, 0, 11'd0, 8'h5A); rop(1, 1, 0, 0, 11'd0, 0); cyc(); // read meets write: old value
      idle(); rop(1, 1, 0, 0, 11'd0, 0); cyc();
      chk("R1 address zero", r_rd, 8'h5A);

      // R3: no drive without enable or output enable
      tag = "R3";
      idle(); lop(1, 0, 0, 0, 11'd5, 0); rop(0, 1, 0, 0, 11'd100, 0); cyc();
      chk("R3 left quiet", {7'd0, l_v}, 8'd0);
      chk("R3 right quiet", r_rd, 8'h00);

      // R2: inhibited write is lost
      tag = "R2";
      idle(); lop(1, 0, 1, 1, 11'd5, 8'hFF); cyc();
      idle(); lop(1, 1, 0, 0, 11'd5, 0); cyc();
      chk("R2 inhibited write", l_rd, 8'hA5);

      // R4: left rings right; byte stored
      tag = "R4";
      idle(); lop(1, 0, 1, 0, 11'h7FF, 8'h11); cyc();
      chk("R4 right irq low", {7'd0, r_irq_n}, 8'd0);
      // R6: enable alone does not clear
      tag = "R6";
      idle(); rop(1, 0, 0, 0, 11'h7FF, 0); cyc();
      chk("R6 no clear without oe", {7'd0, r_irq_n}, 8'd0);
      tag = "R4";
      idle(); rop(1, 1, 0, 0, 11'h7FF, 0); cyc();
      chk("R4 mailbox byte", r_rd, 8'h11);
      chk("R6 right irq cleared", {7'd0, r_irq_n}, 8'd1);

      // R5: right rings left
      tag = "R5";
      idle(); rop(1, 0, 1, 0, 11'h7FE, 8'h77); cyc();
      chk("R5 left irq low", {7'd0, l_irq_n}, 8'd0);
      // R6: clear with write strobe high, also writes
      tag = "R6";
      idle(); lop(1, 1, 1, 0, 11'h7FE, 8'h22); cyc();
      chk("R6 left irq cleared by write access", {7'd0, l_irq_n}, 8'd1);
      idle(); lop(1, 1, 0, 0, 11'h7FE, 0); cyc();
      chk("R6 mailbox rewritten", l_rd, 8'h22);

      // R7: inhibited mailbox write does nothing
      tag = "R7";
      idle(); rop(1, 0, 1, 1, 11'h7FE, 8'h99); cyc();
      chk("R7 left irq unchanged", {7'd0, l_irq_n}, 8'd1);
      idle(); lop(1, 1, 0, 0, 11'h7FE, 0); cyc();
      chk("R7 mailbox byte unchanged", l_rd, 8'h22);

      // R8: set beats clear
      tag = "R8";
      idle(); lop(1, 0, 1, 0, 11'h7FF, 8'h44); rop(1, 1, 0, 0, 11'h7FF, 0); cyc();
      chk("R8 set wins", {7'd0, r_irq_n}, 8'd0);
      chk("R8 old byte read", r_rd, 8'h11);

      // R10: simultaneous write collision
      tag = "R10";
      idle(); lop(1, 0, 1, 0, 11'd200, 8'hC1); rop(1, 0, 1, 0, 11'd200, 8'hD2); cyc();
      idle(); rop(1, 1, 0, 0, 11'd200, 0); cyc();
      chk("R10 left data kept", r_rd, 8'hC1);

      // R9: reset clears flags, keeps memory
      tag = "R9";
      idle(); rop(1, 0, 1, 0, 11'h7FE, 8'h66); cyc();
      idle(); rst_n = 0; cyc();
      chk("R9 left irq reset", {7'd0, l_irq_n}, 8'd1);
      chk("R9 right irq reset", {7'd0, r_irq_n}, 8'd1);
      rst_n = 1; cyc();
      lop(1, 1, 0, 0, 11'h7FF, 0); rop(1, 1, 0, 0, 11'd100, 0); cyc();
      chk("R9 mailbox kept", l_rd, 8'h44);
      chk("R9 word kept", r_rd, 8'h3C);
      idle(); cyc();
   endtask

   initial begin
      fork
         run();
         begin
            repeat (5000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule